// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one clock. A small 32-bit register bus programs it. A shared control word holds a run bit and a 2-bit prescale code for each channel. Each channel also has its own configuration word, which packs a period length and a high-time length, both counted in prescaled ticks. A running channel divides the clock by its prescale ratio (1, 8, 64 or 512). It steps a period counter once per prescaled tick and drives its output high for the first `duty` steps of every period.

Writes are single-cycle: a write strobe with address and data is accepted on the rising clock edge and needs no handshake. Reads are combinational: `reg_rdata` always shows the word that `reg_addr` selects. Each channel copies its period, duty and prescale settings into working copies only when it starts and at the end of each period. Software can therefore reprogram a running channel without producing a shortened or stretched pulse.

Top module: `pwm_quad`

## Requirements
- R1: After reset, the control word and every configuration word read as 0 and every output is low.
- R2: Address decoding uses the word index `reg_addr[ADDR_W-1:2]`, and the low two address bits are ignored:
  - Word 0 is the control word. Bit n is the run bit of channel n. Bits [2n+5:2n+4] are the prescale code of channel n. All other bits read 0.
  - Word n+1 is the configuration word of channel n. The period is in bits [CNT_W-1:0] and the duty is in bits [CNT_W+15:16]. All other bits read 0.
  - Any word index above 4 reads 0, and writes to it change nothing.
- R3: Prescale code c makes each period step last 8^c clock cycles: code 0 gives 1 cycle, code 1 gives 8, code 2 gives 64 and code 3 gives 512. A full period lasts period × 8^c cycles.
- R4: A period field of 0 means 2^CNT_W steps.
- R5: In each period, the output is high for the first duty steps and low for the remaining steps. A duty of 0 keeps the output low.
- R6: If the duty is equal to or greater than the effective period, the output stays high for the whole period.
- R7: New period, duty and prescale values written while a channel runs take effect only from the next period boundary. The period in progress finishes with the old values.
- R8: When a run bit is cleared, that output goes low in the cycle right after the write edge, and the channel's prescaler and step counter restart from zero.
- R9: When a run bit is set, a fresh period starts one cycle after the write edge, using the current configuration. The first step is high unless the duty is 0.
- R10: Channels are independent of each other. A stopped channel's output stays low while other channels run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds the block with `CNT_W` set to 8 and keeps the defaults of four channels and a power-of-eight prescale step. With these values, a period field of 0 gives a 256-step period that can be measured in full. Even the divide-by-512 ratio completes a two-step period in 1024 cycles. The narrow counter also lets the bench check the masking of duty bits above bit 23 on readback, and the clamping of oversized duty values, within short runs.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // Field placement shared by the register file and the checker.
  localparam int CTRL_PRE_LSB  = 4;
  localparam int CFG_DUTY_LSB  = 16;
  localparam int PRE_CODE_W    = 2;
  localparam int BUS_W         = 32;
endpackage

// File: rtl/pwm_quad_prescale.sv
module pwm_quad_prescale #(
  parameter int STEP_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic [1:0] code,
  output logic       tick
);
  // The largest ratio is 2^(3*STEP_LOG2), reached with code 3.
  localparam int PW = 3 * STEP_LOG2;

  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  // The limit has code*STEP_LOG2 low bits set.
  always_comb limit = ~({PW{1'b1}} << (32'(code) * STEP_LOG2));

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel #(
  parameter int CNT_W     = 16,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [1:0]       cfg_pre,
  output logic             pwm
);
  logic             run;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_duty;
  logic [1:0]       act_pre;
  logic             tick;
  logic             last_step;

  pwm_quad_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (~(en & run)),
    .code  (act_pre),
    .tick  (tick)
  );

  // A period of 0 wraps to all ones, so it gives the full 2^CNT_W steps.
  assign last_step = (step == act_period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      step       <= '0;
      act_period <= '0;
      act_duty   <= '0;
      act_pre    <= '0;
    end else if (!en) begin
      run  <= 1'b0;
      step <= '0;
    end else if (!run) begin
      run        <= 1'b1;
      step       <= '0;
      act_period <= cfg_period;
      act_duty   <= cfg_duty;
      act_pre    <= cfg_pre;
    end else if (tick) begin
      if (last_step) begin
        step       <= '0;
        act_period <= cfg_period;
        act_duty   <= cfg_duty;
        act_pre    <= cfg_pre;
      end else begin
        step <= step + CNT_W'(1);
      end
    end
  end

  // Gating with en drops the output as soon as the run bit clears.
  assign pwm = en & run & (step < act_duty);
endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BUS_W-1:0]             wdata,
  output logic [BUS_W-1:0]             rdata,
  output logic [NUM_CH-1:0]            ch_en,
  output logic [NUM_CH-1:0][1:0]       ch_pre,
  output logic [NUM_CH-1:0][CNT_W-1:0] ch_period,
  output logic [NUM_CH-1:0][CNT_W-1:0] ch_duty
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_bits;

  assign word        = addr[ADDR_W-1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en  <= '0;
      ch_pre <= '0;
    end else if (wr && word == '0) begin
      ch_en <= wdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++)
        ch_pre[c] <= wdata[CTRL_PRE_LSB + PRE_CODE_W*c +: PRE_CODE_W];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_period[g] <= '0;
        ch_duty[g]   <= '0;
      end else if (wr && word == WORD_W'(g + 1)) begin
        ch_period[g] <= wdata[CNT_W-1:0];
        ch_duty[g]   <= wdata[CFG_DUTY_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (word == '0) begin
      rdata[NUM_CH-1:0] = ch_en;
      for (int c = 0; c < NUM_CH; c++)
        rdata[CTRL_PRE_LSB + PRE_CODE_W*c +: PRE_CODE_W] = ch_pre[c];
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == WORD_W'(c + 1)) begin
          rdata[CNT_W-1:0]            = ch_period[c];
          rdata[CFG_DUTY_LSB +: CNT_W] = ch_duty[c];
        end
      end
    end
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int CNT_W         = 16,
  parameter int PRE_STEP_LOG2 = 3,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0][1:0]       ch_pre;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_period;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_duty;

  pwm_quad_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .ch_en     (ch_en),
    .ch_pre    (ch_pre),
    .ch_period (ch_period),
    .ch_duty   (ch_duty)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_quad_channel #(.CNT_W(CNT_W), .STEP_LOG2(PRE_STEP_LOG2)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .en         (ch_en[g]),
      .cfg_period (ch_period[g]),
      .cfg_duty   (ch_duty[g]),
      .cfg_pre    (ch_pre[g]),
      .pwm        (pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [31:0]                  reg_rdata,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_duty
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0 && ch_en == '0));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (32'(reg_addr[ADDR_W-1:2]) > NUM_CH) |-> (reg_rdata == '0));

  assert_stopped_low_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_out & ~ch_en) == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_start
    assert_start_level_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_en[g]) ##1 ch_en[g] |-> (pwm_out[g] == ($past(ch_duty[g]) != '0)));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out),
  .ch_en     (ch_en),
  .ch_duty   (ch_duty)
);

// File: tb/pwm_quad_test.sv
`timescale 1ns/1ps
module pwm_quad_test;
  localparam int CNT_W = 8;
  localparam int NV    = 9;
  // Columns: prescale code, period field, duty field, high cycles per period, cycles per period
  localparam int VEC [NV][5] = '{
    '{0, 10,   3,   3,   10},
    '{0, 10,   0,   0,   10},
    '{0, 10,  10,  10,   10},
    '{0, 10, 200,  10,   10},
    '{1,  5,   2,  16,   40},
    '{2,  4,   1,  64,  256},
    '{3,  2,   1, 512, 1024},
    '{0,  0, 100, 100,  256},
    '{0,  1,   1,   1,    1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  pwm_quad #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic measure(input int ch, input int n, output int highs, output bit first,
                         output int others);
    highs = 0; others = 0; first = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
      if (k == 0) first = pwm_out[ch];
      if ((pwm_out & ~(4'(1) << ch)) != 4'd0) others++;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int h, h2, o;
    bit f;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      bus_read(8'(4 * a), rd);
      check(rd == 32'd0, "R1 reset register value", int'(rd), 0);
    end
    check(pwm_out == 4'd0, "R1 outputs low after reset", int'(pwm_out), 0);

    // R2 register map and masking
    bus_write(8'h0C, 32'h00AB_00CD);
    bus_read(8'h0C, rd);
    check(rd == 32'h00AB_00CD, "R2 config readback", int'(rd), 32'h00AB_00CD);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, rd);
    check(rd == 32'h00FF_00FF, "R2 config width masking", int'(rd), 32'h00FF_00FF);
    bus_write(8'h00, 32'hFFFF_FFF0);
    bus_read(8'h00, rd);
    check(rd == 32'h0000_0FF0, "R2 control readback", int'(rd), 32'h0000_0FF0);
    bus_write(8'h00, 32'h0);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h14, rd);
    check(rd == 32'd0, "R2 unmapped word reads zero", int'(rd), 0);
    bus_read(8'h00, rd);
    check(rd == 32'd0, "R2 unmapped write leaves control", int'(rd), 0);
    bus_read(8'h10, rd);
    check(rd == 32'd0, "R2 unmapped write leaves channel 3", int'(rd), 0);
    bus_read(8'h0E, rd);
    check(rd == 32'h00FF_00FF, "R2 low address bits ignored", int'(rd), 32'h00FF_00FF);

    // Vector table: R3 R4 R5 R6 and R9 start level
    for (int i = 0; i < NV; i++) begin
      int ch;
      string tag;
      ch = i % 4;
      if (VEC[i][1] == 0)               tag = "R4";
      else if (VEC[i][0] != 0)          tag = "R3";
      else if (VEC[i][2] >= VEC[i][1])  tag = "R6";
      else                              tag = "R5";
      bus_write(8'h00, 32'h0);
      bus_write(8'(4 + 4 * ch), (32'(VEC[i][2]) << 16) | 32'(VEC[i][1]));
      bus_write(8'h00, (32'd1 << ch) | (32'(VEC[i][0]) << (2 * ch + 4)));
      @(posedge clk);
      measure(ch, 2 * VEC[i][4], h, f, o);
      check(h == 2 * VEC[i][3], {tag, " high cycles over two periods"}, h, 2 * VEC[i][3]);
      check(f == (VEC[i][2] != 0), "R9 first step level", int'(f), int'(VEC[i][2] != 0));
      check(o == 0, "R10 other channels low", o, 0);
    end

    // R7 duty change mid-period
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, (32'd3 << 16) | 32'd10);
    bus_write(8'h00, 32'h1);
    @(posedge clk);
    h = 0; h2 = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out[0]) begin
        if (k < 10) h++; else h2++;
      end
      if (k == 4) begin reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = (32'd7 << 16) | 32'd10; end
      if (k == 5) reg_wr = 1'b0;
    end
    check(h == 3, "R7 current period keeps old duty", h, 3);
    check(h2 == 7, "R7 next period uses new duty", h2, 7);

    // R7 prescale change mid-period (also R3)
    bus_write(8'h00, 32'h0);
    bus_write(8'h08, (32'd2 << 16) | 32'd4);
    bus_write(8'h00, 32'h2);
    @(posedge clk);
    h = 0; h2 = 0;
    for (int k = 0; k < 36; k++) begin
      @(negedge clk);
      if (pwm_out[1]) begin
        if (k < 4) h++; else h2++;
      end
      if (k == 1) begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h42; end
      if (k == 2) reg_wr = 1'b0;
    end
    check(h == 2, "R7 period in progress keeps old prescale", h, 2);
    check(h2 == 16, "R7 R3 next period uses divide by 8", h2, 16);

    // R8 disable forces low at once
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, (32'd8 << 16) | 32'd10);
    bus_write(8'h00, 32'h1);
    @(posedge clk);
    h = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 1) check(pwm_out[0] == 1'b1, "R8 output high before disable", int'(pwm_out[0]), 1);
      if (k >= 3 && pwm_out[0]) h++;
      if (k == 2) begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0; end
      if (k == 3) reg_wr = 1'b0;
    end
    check(h == 0, "R8 output low after disable", h, 0);

    // R8 R9 restart mid-step gives a clean period
    bus_write(8'h0C, (32'd2 << 16) | 32'd5);
    bus_write(8'h00, 32'h104);
    repeat (13) @(negedge clk);
    bus_write(8'h00, 32'h0);
    check(pwm_out[2] == 1'b0, "R8 low right after disable write", int'(pwm_out[2]), 0);
    bus_write(8'h00, 32'h104);
    @(posedge clk);
    measure(2, 40, h, f, o);
    check(h == 16, "R8 restarted prescaler gives full period", h, 16);
    check(f == 1'b1, "R9 restart begins high", int'(f), 1);

    // R10 two channels at once
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, (32'd1 << 16) | 32'd4);
    bus_write(8'h10, (32'd3 << 16) | 32'd6);
    bus_write(8'h00, 32'h9);
    @(posedge clk);
    h = 0; h2 = 0; o = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pwm_out[0]) h++;
      if (pwm_out[3]) h2++;
      if (pwm_out[1] | pwm_out[2]) o++;
    end
    check(h == 3, "R10 channel 0 duty", h, 3);
    check(h2 == 6, "R10 channel 3 duty", h2, 6);
    check(o == 0, "R10 stopped channels low", o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule